// File: doc/BRIEF.md
# SMM memory window lock controller

This block holds one 8-bit control register for a protected system-management memory window and decodes each memory access against it. The window covers 128 kB at 0xA0000 to 0xBFFFF. An access that meets the visibility rules is sent to local DRAM. Every other valid access is forwarded upstream. Memory is never remapped: the window is only made visible or hidden.

Firmware uses the open bit to fill the window from outside SMM. It then sets the lock bit, which clears open and freezes the enable, open and lock bits until a full reset. The registered lock flag is exported, so that neighbouring register groups become read-only in the same cycle.

Top module: `smm_window_ctrl`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x02 and `lock_o` is 0.
- R2: Bit 7 of `cfg_rd_data` always reads 0, and bits 2:0 always read 3'b010, whatever value is written.
- R3: While the global enable (bit 3) is 0, no access reaches DRAM, whatever the open (bit 6), close (bit 5) and lock (bit 4) bits hold.
- R4: Only addresses 0xA0000 to 0xBFFFF inclusive can reach DRAM. An address outside that range is always forwarded upstream.
- R5: With enable 1 and close 0, an SMM-mode access to the window reaches DRAM, for both code (`acc_code`=1) and data (`acc_code`=0).
- R6: With enable 1 and close 1, an SMM-mode data access to the window is forwarded upstream, and an SMM-mode code access still reaches DRAM.
- R7: A non-SMM access to the window reaches DRAM only when enable is 1, open is 1 and lock is 0. Otherwise it is forwarded upstream.
- R8: A write with bit 4 set leaves open at 0, even when the same write sets bit 6. From the next cycle, `lock_o` is 1 and reads back in bit 4.
- R9: While lock is 1, writes do not change the enable, open or lock bits. The close bit stays writable.
- R10: Once set, lock is cleared only by reset. A configuration write of 0 leaves it at 1.
- R11: With open and close both 1 and lock 0, a non-SMM access reaches DRAM, an SMM data access is forwarded upstream, and an SMM code access reaches DRAM.
- R12: A cycle with `acc_valid` high raises exactly one of `acc_to_dram` and `acc_to_upstream`. A cycle with `acc_valid` low raises neither. With the default DECODE_REG=0 these outputs are combinational in the same cycle. With DECODE_REG=1 they follow one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous full reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration write value |
| cfg_rd_data | output | 8 | Current register value |
| lock_o | output | 1 | Registered lock flag for other register groups |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_smm | input | 1 | Access is made in SMM mode |
| acc_code | input | 1 | 1 for a code fetch, 0 for a data reference |
| acc_to_dram | output | 1 | Access is served by local DRAM |
| acc_to_upstream | output | 1 | Access is forwarded upstream |

## Verification
The assertions take the access bundle (`acc_addr`, `acc_smm`, `acc_code`) as stable and meaningful only while `acc_valid` is high. They also assume that a register write and the accesses it should govern fall in separate cycles. The bench follows both rules. It drives every input on the falling edge and raises `acc_valid` only with a full bundle. It issues configuration writes in cycles of their own, with no access in them. Random addresses are drawn so that most fall near or inside the window, including both boundaries.

// File: rtl/smw_pkg.sv
package smw_pkg;
   localparam int unsigned CFG_W     = 8;
   localparam int unsigned BIT_OPEN  = 6;
   localparam int unsigned BIT_CLOSE = 5;
   localparam int unsigned BIT_LOCK  = 4;
   localparam int unsigned BIT_GEN   = 3;
   localparam int unsigned SEG_W     = 3;

   typedef struct packed {
      logic open;
      logic close;
      logic lock;
      logic gen;
   } smw_ctl_t;
endpackage

// File: rtl/smw_cfg_reg.sv
module smw_cfg_reg
   import smw_pkg::*;
#(
   parameter logic [SEG_W-1:0] BASE_SEG = 3'b010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output smw_ctl_t         ctl,
   output logic [CFG_W-1:0] rd_data
);
   smw_ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         ctl_q.close <= wr_data[BIT_CLOSE];
         if (!ctl_q.lock) begin
            ctl_q.gen  <= wr_data[BIT_GEN];
            ctl_q.lock <= wr_data[BIT_LOCK];
            ctl_q.open <= wr_data[BIT_OPEN] & ~wr_data[BIT_LOCK];
         end
      end
   end

   always_comb begin
      rd_data            = '0;
      rd_data[SEG_W-1:0] = BASE_SEG;
      rd_data[BIT_GEN]   = ctl_q.gen;
      rd_data[BIT_LOCK]  = ctl_q.lock;
      rd_data[BIT_CLOSE] = ctl_q.close;
      rd_data[BIT_OPEN]  = ctl_q.open;
   end

   assign ctl = ctl_q;
endmodule

// File: rtl/smw_decode.sv
module smw_decode
   import smw_pkg::*;
#(
   parameter int unsigned      ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 'h000A_0000,
   parameter int unsigned      WIN_LOG2   = 17,
   parameter bit               DECODE_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  smw_ctl_t          ctl,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_smm,
   input  logic              acc_code,
   output logic              to_dram,
   output logic              to_up
);
   localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;
   localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

   logic in_win;
   logic smm_ok;
   logic open_ok;
   logic hit;

   assign in_win  = (acc_addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
   assign smm_ok  = ~(ctl.close & ~acc_code);
   assign open_ok = ctl.open & ~ctl.lock;
   assign hit     = acc_valid & ctl.gen & in_win & (acc_smm ? smm_ok : open_ok);

   generate
      if (DECODE_REG) begin : g_reg
         logic dram_q, up_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dram_q <= 1'b0;
               up_q   <= 1'b0;
            end else begin
               dram_q <= hit;
               up_q   <= acc_valid & ~hit;
            end
         end
         assign to_dram = dram_q;
         assign to_up   = up_q;
      end else begin : g_comb
         assign to_dram = hit;
         assign to_up   = acc_valid & ~hit;
      end
   endgenerate
endmodule

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl
   import smw_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 'h000A_0000,
   parameter int unsigned       WIN_LOG2   = 17,
   parameter logic [2:0]        BASE_SEG   = 3'b010,
   parameter bit                DECODE_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [7:0]        cfg_wr_data,
   output logic [7:0]        cfg_rd_data,
   output logic              lock_o,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_smm,
   input  logic              acc_code,
   output logic              acc_to_dram,
   output logic              acc_to_upstream
);
   generate
      if (ADDR_W < 20 || ADDR_W > 64) begin : g_bad_aw
         $error("smm_window_ctrl: ADDR_W out of range");
      end
      if (WIN_LOG2 < 12 || WIN_LOG2 >= ADDR_W) begin : g_bad_win
         $error("smm_window_ctrl: WIN_LOG2 out of range");
      end
      if (WIN_BASE[WIN_LOG2-1:0] != '0) begin : g_bad_align
         $error("smm_window_ctrl: WIN_BASE not aligned to window size");
      end
   endgenerate

   smw_ctl_t ctl;

   smw_cfg_reg #(.BASE_SEG(BASE_SEG)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_data (cfg_wr_data),
      .ctl     (ctl),
      .rd_data (cfg_rd_data)
   );

   smw_decode #(
      .ADDR_W     (ADDR_W),
      .WIN_BASE   (WIN_BASE),
      .WIN_LOG2   (WIN_LOG2),
      .DECODE_REG (DECODE_REG)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_smm   (acc_smm),
      .acc_code  (acc_code),
      .to_dram   (acc_to_dram),
      .to_up     (acc_to_upstream)
   );

   assign lock_o = ctl.lock;
endmodule

// File: rtl/smw_checker.sv
module smw_checker #(
   parameter int unsigned       ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 'h000A_0000,
   parameter int unsigned       WIN_LOG2   = 17,
   parameter bit                DECODE_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_en,
   input logic [7:0]        cfg_wr_data,
   input logic [7:0]        cfg_rd_data,
   input logic              lock_o,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_smm,
   input logic              acc_code,
   input logic              acc_to_dram,
   input logic              acc_to_upstream
);
   logic in_win;
   assign in_win = (acc_addr >= WIN_BASE) &&
                   (acc_addr <= WIN_BASE + ADDR_W'((64'd1 << WIN_LOG2) - 64'd1));

   p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_data[7] == 1'b0 && cfg_rd_data[2:0] == 3'b010);

   p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |=> lock_o);

   p_lock_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |=> $stable(cfg_rd_data[6]) && $stable(cfg_rd_data[3]));

   p_lock_clears_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |-> !cfg_rd_data[6]);

   p_lock_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o == cfg_rd_data[4]);

   generate
      if (DECODE_REG) begin : g_reg
         p_one_hot_r12: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid |=> acc_to_dram ^ acc_to_upstream);
         p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_valid |=> !acc_to_dram && !acc_to_upstream);
         p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid && !cfg_rd_data[3] |=> !acc_to_dram);
         p_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid && !in_win |=> acc_to_upstream);
         p_closed_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid && acc_smm && !acc_code && cfg_rd_data[5] |=> !acc_to_dram);
      end else begin : g_comb
         p_one_hot_r12: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid |-> acc_to_dram ^ acc_to_upstream);
         p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_valid |-> !acc_to_dram && !acc_to_upstream);
         p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid && !cfg_rd_data[3] |-> !acc_to_dram);
         p_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid && !in_win |-> acc_to_upstream);
         p_closed_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid && acc_smm && !acc_code && cfg_rd_data[5] |-> !acc_to_dram);
      end
   endgenerate
endmodule

bind smm_window_ctrl smw_checker #(
   .ADDR_W     (ADDR_W),
   .WIN_BASE   (WIN_BASE),
   .WIN_LOG2   (WIN_LOG2),
   .DECODE_REG (DECODE_REG)
) u_smw_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_wr_en       (cfg_wr_en),
   .cfg_wr_data     (cfg_wr_data),
   .cfg_rd_data     (cfg_rd_data),
   .lock_o          (lock_o),
   .acc_valid       (acc_valid),
   .acc_addr        (acc_addr),
   .acc_smm         (acc_smm),
   .acc_code        (acc_code),
   .acc_to_dram     (acc_to_dram),
   .acc_to_upstream (acc_to_upstream)
);

// File: tb/smm_window_ctrl_bench.sv
module smm_window_ctrl_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_wr_data = '0;
   logic [7:0]  cfg_rd_data;
   logic        lock_o;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_smm = 1'b0;
   logic        acc_code = 1'b0;
   logic        acc_to_dram;
   logic        acc_to_upstream;

   int n_chk = 0;
   int n_bad = 0;

   logic m_open, m_close, m_lock, m_gen;

   always #(CLK_P/2) clk = ~clk;

   smm_window_ctrl u_smm_window_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_wr_en       (cfg_wr_en),
      .cfg_wr_data     (cfg_wr_data),
      .cfg_rd_data     (cfg_rd_data),
      .lock_o          (lock_o),
      .acc_valid       (acc_valid),
      .acc_addr        (acc_addr),
      .acc_smm         (acc_smm),
      .acc_code        (acc_code),
      .acc_to_dram     (acc_to_dram),
      .acc_to_upstream (acc_to_upstream)
   );

   function automatic logic [7:0] exp_reg();
      return {1'b0, m_open, m_close, m_lock, m_gen, 3'b010};
   endfunction

   function automatic logic exp_dram(input logic [31:0] a, input logic smm,
                                     input logic code, input logic v);
      logic win;
      win = (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
      if (!v || !m_gen || !win) return 1'b0;
      if (smm) return !(m_close && !code);
      return m_open && !m_lock;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_open = 0; m_close = 0; m_lock = 0; m_gen = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
      m_close = d[5];
      if (!m_lock) begin
         m_gen  = d[3];
         m_lock = d[4];
         m_open = d[6] & ~d[4];
      end
   endtask

   task automatic chk_reg(input string tag);
      #1;
      chk({tag, " reg"}, {24'd0, cfg_rd_data}, {24'd0, exp_reg()});
      chk({tag, " lock_o"}, {31'd0, lock_o}, {31'd0, m_lock});
   endtask

   task automatic acc(input string tag, input logic [31:0] a, input logic smm,
                      input logic code, input logic v);
      logic e;
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_smm = smm; acc_code = code;
      #1;
      e = exp_dram(a, smm, code, v);
      chk(tag, {30'd0, acc_to_dram, acc_to_upstream}, {30'd0, e, v & ~e});
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   function automatic logic [31:0] rnd_addr();
      case ($urandom % 4)
         0: return 32'h000A_0000 + ($urandom % 32'h2_0000);
         1: return 32'h0009_FFF0 + ($urandom % 32'h20);
         2: return 32'h000B_FFF0 + ($urandom % 32'h20);
         default: return $urandom % 32'h0010_0000;
      endcase
   endfunction

   task automatic rnd_phase(input int n, input logic keep_unlocked, input string tag);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         if (keep_unlocked) d[4] = 1'b0;
         wr(d);
         chk_reg({tag, " R9 reg after random write"});
         for (int j = 0; j < 3; j++) begin
            acc({tag, " R12 random access"}, rnd_addr(), 1'($urandom), 1'($urandom),
                ($urandom % 8) != 0);
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd2024);
      model_reset();
      do_reset();
      chk_reg("R1 reset value");

      wr(8'h87);
      chk_reg("R2 reserved and base bits fixed");
      wr(8'h70 & 8'h60);
      chk_reg("R2 open/close without enable");
      acc("R3 disabled non-SMM", 32'h000A_1000, 1'b0, 1'b0, 1'b1);
      acc("R3 disabled SMM code", 32'h000B_0000, 1'b1, 1'b1, 1'b1);

      wr(8'h08);
      acc("R5 SMM data", 32'h000A_4000, 1'b1, 1'b0, 1'b1);
      acc("R5 SMM code", 32'h000A_4000, 1'b1, 1'b1, 1'b1);
      acc("R4 low edge", 32'h000A_0000, 1'b1, 1'b0, 1'b1);
      acc("R4 high edge", 32'h000B_FFFF, 1'b1, 1'b0, 1'b1);
      acc("R4 below window", 32'h0009_FFFF, 1'b1, 1'b0, 1'b1);
      acc("R4 above window", 32'h000C_0000, 1'b1, 1'b1, 1'b1);
      acc("R4 high address alias", 32'h100A_0000, 1'b1, 1'b1, 1'b1);
      acc("R7 non-SMM closed", 32'h000A_4000, 1'b0, 1'b0, 1'b1);
      acc("R12 idle", 32'h000A_4000, 1'b1, 1'b0, 1'b0);

      wr(8'h28);
      acc("R6 closed SMM data", 32'h000B_1000, 1'b1, 1'b0, 1'b1);
      acc("R6 closed SMM code", 32'h000B_1000, 1'b1, 1'b1, 1'b1);

      wr(8'h48);
      acc("R7 open non-SMM", 32'h000A_8000, 1'b0, 1'b0, 1'b1);

      wr(8'h68);
      chk_reg("R11 open and close both set");
      acc("R11 non-SMM data", 32'h000A_8000, 1'b0, 1'b0, 1'b1);
      acc("R11 SMM data", 32'h000A_8000, 1'b1, 1'b0, 1'b1);
      acc("R11 SMM code", 32'h000A_8000, 1'b1, 1'b1, 1'b1);

      rnd_phase(150, 1'b1, "unlocked");

      wr(8'h58);
      chk_reg("R8 lock with open in same write");
      acc("R8 non-SMM after lock", 32'h000A_0100, 1'b0, 1'b0, 1'b1);
      wr(8'h40);
      chk_reg("R9 writes ignored while locked");
      wr(8'h00);
      chk_reg("R10 write zero keeps lock");
      wr(8'h20);
      chk_reg("R9 close still writable");
      acc("R9 locked closed SMM data", 32'h000A_0100, 1'b1, 1'b0, 1'b1);
      rnd_phase(60, 1'b0, "locked");

      do_reset();
      chk_reg("R10 reset clears lock");
      acc("R1 after reset disabled", 32'h000A_0100, 1'b1, 1'b1, 1'b1);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule